// File: doc/BRIEF.md
# Command/Response FIFO Engine

This block is the command engine that sits behind a byte-wide data FIFO register and a status register of one access locality. A host pushes a command byte by byte into a shared buffer. The engine reads the big-endian length carried in header bytes 2 to 5 and keeps an expect flag raised until that many bytes have arrived. A go request hands the buffered command to an execution unit through a start/done handshake. The execution unit writes its response into the same buffer. The host then drains the response byte by byte, can rewind it with a retry request, and can return the engine to the ready state at any time.

The engine has five states, coded IDLE=0, READY=1, COMPLETION=2, EXECUTION=3 and RECEPTION=4. Register traffic counts only while the active-locality input is high. Arbitration between localities and interrupt masking sit outside the block. Instead, three one-cycle event strobes report the ready, status-valid and data-available events. A burst count output tells the host how many response bytes remain, or how much buffer space is free.

Top module: `cmdRspEngine`

## Requirements
- R1: After reset the engine is in IDLE (code 0), every status flag is clear except the constant family field, and the burst count equals the buffer depth.
- R2: A status write (wrSel=1) acts only when isActive is high and exactly one of its request bits is set: bit 0 command-ready, bit 1 go, bit 2 retry. Any other write leaves the state unchanged.
- R3: A command-ready request in IDLE enters READY, sets the ready flag and pulses evReady. In READY the same request only rewinds the buffer pointer and raises no event.
- R4: A command-ready request in RECEPTION aborts at once: the engine returns to READY with the pointer rewound, only ready set, and an evReady pulse. In EXECUTION the request pulses cancelReq, and the next execDone leads to READY with ready set instead of to COMPLETION.
- R5: The first FIFO write in READY stores the byte, enters RECEPTION and sets expect and valid. FIFO writes in IDLE, EXECUTION or COMPLETION, and all writes while isActive is low, are dropped and leave the burst count unchanged.
- R6: Once 6 or more bytes are buffered, expect stays set while the big-endian length in header bytes 2..5 exceeds the byte count, and clears when the count reaches that length. Later FIFO writes are dropped.
- R7: A FIFO write that finds the buffer full stores nothing and clears expect, leaving valid set.
- R8: A go request is taken only in RECEPTION with expect clear. It enters EXECUTION, pulses execStart and presents the byte count on execLen. Otherwise it is ignored.
- R9: execDone in EXECUTION enters COMPLETION, sets valid and data-available, rewinds the pointer, and pulses evData and evValid.
- R10: In COMPLETION with data-available set, FIFO reads return response bytes in buffer order, up to the length in header bytes 2..5. Reading the last byte clears data-available, keeps valid and pulses evValid. Every other read returns 0xFF and does not move the pointer.
- R11: The burst count is the number of remaining response bytes while data-available is set, and the free buffer space otherwise. With byteView high the free-space figure is capped at 255.
- R12: A retry request in COMPLETION rewinds the read pointer and sets valid and data-available again. In any other state it has no effect.
- R13: A command-ready request in COMPLETION enters READY, rewinds the pointer and clears data-available. If ready was clear it also sets ready (clearing valid) and pulses evReady.
- R14: Each status rewrite keeps the family field (stsOut[6:5]) and the self-test-done flag (stsOut[4]). The flag is set when execDone arrives with execSelftest high and is cleared only by reset. Status bits are: 0 ready, 1 valid, 2 data-available, 3 expect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isActive | input | 1 | This locality currently owns the interface |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 data FIFO, 1 status |
| wrData | input | 8 | Write byte |
| rdFifo | input | 1 | Data FIFO read strobe |
| byteView | input | 1 | Status is being read one byte wide (caps free space) |
| rdData | output | 8 | FIFO read byte (0xFF when nothing to return) |
| stsOut | output | 8 | Status flags, family and self-test flag |
| burstCount | output | BURST_W | Remaining response bytes or free space |
| engState | output | 3 | Current state code |
| evReady | output | 1 | Ready event strobe |
| evValid | output | 1 | Status-valid event strobe |
| evData | output | 1 | Data-available event strobe |
| execStart | output | 1 | Start strobe to the execution unit |
| execLen | output | CNT_W | Command length handed over with execStart |
| cancelReq | output | 1 | Cancel request to the execution unit |
| rspWrEn | input | 1 | Execution unit response byte write |
| rspAddr | input | ADDR_W | Response byte address |
| rspData | input | 8 | Response byte |
| execDone | input | 1 | Execution finished |
| execSelftest | input | 1 | Finished command completed the self-test |

## Verification
The bench targets the completeness threshold: expect must drop exactly at the declared length and never before byte 6. A design off by one there would start execution early or stall a complete command. It fills the buffer past its end with an oversized header, where a wrong design would write out of range or keep expect high forever. It also aborts in both RECEPTION and EXECUTION, where a wrong design would land in COMPLETION or lose the cancel pulse. It mixes retry rewinds into partial response reads, where a bad pointer would return shifted bytes or a wrong burst count. Finally it checks that ignored requests (go too early, retry outside COMPLETION, multi-bit writes, inactive access) leave state and counts untouched.

// File: rtl/cmdRspPkg.sv
package cmdRspPkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READY    = 3'd1,
    ST_COMPLETE = 3'd2,
    ST_EXEC     = 3'd3,
    ST_RECV     = 3'd4
  } engState_t;

  typedef struct packed {
    logic ptrClr;
    logic ptrInc;
    logic hostWr;
    logic rspAllow;
  } dpCtl_t;

  localparam int HDR_MIN = 6;
endpackage

// File: rtl/cmdRspData.sv
module cmdRspData
  import cmdRspPkg::*;
#(
  parameter int DEPTH   = 320,
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int BURST_W = (CNT_W > 8) ? CNT_W : 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [7:0]         hostData,
  input  logic               rspWrEn,
  input  logic [ADDR_W-1:0]  rspAddr,
  input  logic [7:0]         rspData,
  input  logic               dataAvail,
  input  logic               byteView,
  output logic [CNT_W-1:0]   ptr,
  output logic [31:0]        hdrLenNext,
  output logic [7:0]         rdByte,
  output logic [BURST_W-1:0] burst,
  output logic               lastByte
);
  logic [7:0] mem [DEPTH];
  logic [0:3][7:0] hdrCur;
  logic [0:3][7:0] hdrNx;
  logic [31:0] hdrLen;
  logic [CNT_W-1:0] rspLen;
  logic [BURST_W-1:0] freeSpace;
  logic rspInRange;

  assign rspInRange = 32'(rspAddr) < DEPTH;

  always_ff @(posedge clk) begin
    if (ctl.hostWr) mem[ptr[ADDR_W-1:0]] <= hostData;
    else if (ctl.rspAllow && rspWrEn && rspInRange) mem[rspAddr] <= rspData;
  end

  // header bytes 2..5 shadowed in registers so the length is visible
  // in the same cycle the last header byte arrives
  for (genvar k = 0; k < 4; k++) begin : g_hdr
    localparam logic [CNT_W-1:0]  HPOS = CNT_W'(k + 2);
    localparam logic [ADDR_W-1:0] APOS = ADDR_W'(k + 2);
    logic [7:0] hdrQ;
    always_ff @(posedge clk) begin
      if (!rstN) hdrQ <= '0;
      else if (ctl.hostWr && ptr == HPOS) hdrQ <= hostData;
      else if (ctl.rspAllow && rspWrEn && rspAddr == APOS) hdrQ <= rspData;
    end
    assign hdrCur[k] = hdrQ;
    assign hdrNx[k]  = (ctl.hostWr && ptr == HPOS) ? hostData : hdrQ;
  end

  assign hdrLen     = hdrCur;
  assign hdrLenNext = hdrNx;
  assign rspLen     = (hdrLen > 32'(DEPTH)) ? CNT_W'(DEPTH) : hdrLen[CNT_W-1:0];
  assign lastByte   = ({1'b0, ptr} + 1'b1) >= {1'b0, rspLen};

  always_ff @(posedge clk) begin
    if (!rstN)           ptr <= '0;
    else if (ctl.ptrClr) ptr <= '0;
    else if (ctl.ptrInc) ptr <= ptr + 1'b1;
  end

  assign rdByte = (32'(ptr) < DEPTH) ? mem[ptr[ADDR_W-1:0]] : 8'hFF;

  always_comb begin
    freeSpace = BURST_W'(DEPTH) - BURST_W'(ptr);
    if (byteView && freeSpace > BURST_W'(255)) freeSpace = BURST_W'(255);
    burst = dataAvail ? BURST_W'(rspLen - ptr) : freeSpace;
  end
endmodule

// File: rtl/cmdRspCtrl.sv
module cmdRspCtrl
  import cmdRspPkg::*;
#(
  parameter int          DEPTH  = 320,
  parameter int          CNT_W  = $clog2(DEPTH + 1),
  parameter logic [1:0]  FAMILY = 2'b01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isActive,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [2:0]       cmdBits,
  input  logic             rdFifo,
  input  logic             execDone,
  input  logic             execSelftest,
  input  logic [CNT_W-1:0] ptr,
  input  logic [31:0]      hdrLenNext,
  input  logic             lastByte,
  output dpCtl_t           ctl,
  output engState_t        state,
  output logic [7:0]       sts,
  output logic             evReady,
  output logic             evValid,
  output logic             evData,
  output logic             execStart,
  output logic             cancelReq
);
  engState_t nxtState;
  logic rdyQ, vldQ, davQ, expQ, stQ, abtQ;
  logic rdyN, vldN, davN, expN, stN, abtN;
  logic stsWr, reqRdy, reqGo, reqRetry, fifoWr, fifoRd;
  logic doW, vldPrev;
  logic [CNT_W-1:0] cntNext;

  assign stsWr    = wrEn && wrSel && isActive;
  assign reqRdy   = stsWr && cmdBits == 3'b001;
  assign reqGo    = stsWr && cmdBits == 3'b010;
  assign reqRetry = stsWr && cmdBits == 3'b100;
  assign fifoWr   = wrEn && !wrSel && isActive;
  assign fifoRd   = rdFifo && isActive;
  assign cntNext  = ptr + 1'b1;

  always_comb begin
    nxtState = state;
    rdyN = rdyQ; vldN = vldQ; davN = davQ; expN = expQ;
    stN = stQ; abtN = abtQ;
    ctl = '0;
    evReady = 1'b0; evValid = 1'b0; evData = 1'b0;
    execStart = 1'b0; cancelReq = 1'b0;
    doW = 1'b0; vldPrev = vldQ;
    case (state)
      ST_IDLE: if (reqRdy) begin
        nxtState = ST_READY;
        rdyN = 1'b1; vldN = 1'b0; davN = 1'b0; expN = 1'b0;
        evReady = 1'b1;
      end
      ST_READY: begin
        if (reqRdy) ctl.ptrClr = 1'b1;
        else if (fifoWr) begin
          nxtState = ST_RECV;
          rdyN = 1'b0; vldN = 1'b1; davN = 1'b0; expN = 1'b1;
          vldPrev = 1'b1;
          doW = 1'b1;
        end
      end
      ST_RECV: begin
        if (reqRdy) begin
          nxtState = ST_READY;
          ctl.ptrClr = 1'b1;
          rdyN = 1'b1; vldN = 1'b0; davN = 1'b0; expN = 1'b0;
          evReady = 1'b1;
        end else if (reqGo && !expQ) begin
          nxtState = ST_EXEC;
          execStart = 1'b1;
        end else if (fifoWr && expQ) doW = 1'b1;
      end
      ST_EXEC: begin
        ctl.rspAllow = 1'b1;
        if (execDone) begin
          stN = stQ | execSelftest;
          ctl.ptrClr = 1'b1;
          abtN = 1'b0;
          if (abtQ || reqRdy) begin
            nxtState = ST_READY;
            rdyN = 1'b1; vldN = 1'b0; davN = 1'b0; expN = 1'b0;
            evReady = 1'b1;
          end else begin
            nxtState = ST_COMPLETE;
            rdyN = 1'b0; vldN = 1'b1; davN = 1'b1; expN = 1'b0;
            evData = 1'b1; evValid = 1'b1;
          end
        end else if (reqRdy) begin
          abtN = 1'b1;
          cancelReq = 1'b1;
        end
      end
      ST_COMPLETE: begin
        if (reqRdy) begin
          nxtState = ST_READY;
          ctl.ptrClr = 1'b1;
          if (!rdyQ) begin
            rdyN = 1'b1; vldN = 1'b0; expN = 1'b0;
            evReady = 1'b1;
          end
          davN = 1'b0;
        end else if (reqRetry) begin
          ctl.ptrClr = 1'b1;
          rdyN = 1'b0; vldN = 1'b1; davN = 1'b1; expN = 1'b0;
        end else if (fifoRd && davQ) begin
          ctl.ptrInc = 1'b1;
          if (lastByte) begin
            rdyN = 1'b0; vldN = 1'b1; davN = 1'b0; expN = 1'b0;
            evValid = 1'b1;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase

    // command byte store and completeness check
    if (doW) begin
      if (32'(ptr) < DEPTH) begin
        ctl.hostWr = 1'b1;
        ctl.ptrInc = 1'b1;
        if (32'(cntNext) >= HDR_MIN) begin
          rdyN = 1'b0; vldN = 1'b1; davN = 1'b0;
          expN = hdrLenNext > 32'(cntNext);
          if (!vldPrev) evValid = 1'b1;
        end
      end else begin
        rdyN = 1'b0; vldN = 1'b1; davN = 1'b0; expN = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rdyQ <= 1'b0; vldQ <= 1'b0; davQ <= 1'b0; expQ <= 1'b0;
      stQ <= 1'b0; abtQ <= 1'b0;
    end else begin
      state <= nxtState;
      rdyQ <= rdyN; vldQ <= vldN; davQ <= davN; expQ <= expN;
      stQ <= stN; abtQ <= abtN;
    end
  end

  assign sts = {1'b0, FAMILY, stQ, expQ, davQ, vldQ, rdyQ};
endmodule

// File: rtl/cmdRspEngine.sv
module cmdRspEngine
  import cmdRspPkg::*;
#(
  parameter int          DEPTH   = 320,
  parameter logic [1:0]  FAMILY  = 2'b01,
  localparam int         ADDR_W  = $clog2(DEPTH),
  localparam int         CNT_W   = $clog2(DEPTH + 1),
  localparam int         BURST_W = (CNT_W > 8) ? CNT_W : 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               isActive,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [7:0]         wrData,
  input  logic               rdFifo,
  input  logic               byteView,
  output logic [7:0]         rdData,
  output logic [7:0]         stsOut,
  output logic [BURST_W-1:0] burstCount,
  output logic [2:0]         engState,
  output logic               evReady,
  output logic               evValid,
  output logic               evData,
  output logic               execStart,
  output logic [CNT_W-1:0]   execLen,
  output logic               cancelReq,
  input  logic               rspWrEn,
  input  logic [ADDR_W-1:0]  rspAddr,
  input  logic [7:0]         rspData,
  input  logic               execDone,
  input  logic               execSelftest
);
  dpCtl_t           ctl;
  engState_t        state;
  logic [CNT_W-1:0] ptr;
  logic [31:0]      hdrLenNext;
  logic [7:0]       rdByte;
  logic             lastByte;

  cmdRspCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .FAMILY(FAMILY)) u_ctrl (
    .clk, .rstN, .isActive, .wrEn, .wrSel,
    .cmdBits(wrData[2:0]), .rdFifo, .execDone, .execSelftest,
    .ptr, .hdrLenNext, .lastByte, .ctl, .state, .sts(stsOut),
    .evReady, .evValid, .evData, .execStart, .cancelReq
  );

  cmdRspData #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_data (
    .clk, .rstN, .ctl, .hostData(wrData), .rspWrEn, .rspAddr, .rspData,
    .dataAvail(stsOut[2]), .byteView, .ptr, .hdrLenNext, .rdByte,
    .burst(burstCount), .lastByte
  );

  assign engState = state;
  assign execLen  = ptr;
  assign rdData   = (state == ST_COMPLETE && stsOut[2] && isActive) ? rdByte : 8'hFF;
endmodule

// File: rtl/cmdRspCheck.sv
module cmdRspCheck #(
  parameter int          DEPTH   = 320,
  parameter logic [1:0]  FAMILY  = 2'b01,
  localparam int         CNT_W   = $clog2(DEPTH + 1),
  localparam int         BURST_W = (CNT_W > 8) ? CNT_W : 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               byteView,
  input logic [7:0]         rdData,
  input logic [7:0]         stsOut,
  input logic [BURST_W-1:0] burstCount,
  input logic [2:0]         engState,
  input logic               evData,
  input logic               execStart
);
  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    engState <= 3'd4);
  p_expect_recv_r6: assert property (@(posedge clk) disable iff (!rstN)
    stsOut[3] |-> engState == 3'd4);
  p_start_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
    execStart |=> engState == 3'd3);
  p_done_cmpl_r9: assert property (@(posedge clk) disable iff (!rstN)
    evData |=> (engState == 3'd2 && stsOut[2] && stsOut[1]));
  p_avail_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    stsOut[2] |-> stsOut[1]);
  p_nodata_r10: assert property (@(posedge clk) disable iff (!rstN)
    engState != 3'd2 |-> rdData == 8'hFF);
  p_burst_cap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (byteView && !stsOut[2]) |-> burstCount <= BURST_W'(255));
  p_selftest_sticky_r14: assert property (@(posedge clk) disable iff (!rstN)
    stsOut[4] |=> stsOut[4]);
  p_family_keep_r14: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(stsOut[6:5]));
endmodule

bind cmdRspEngine cmdRspCheck #(.DEPTH(DEPTH), .FAMILY(FAMILY)) i_check (.*);

// File: tb/test_cmdRspEngine.sv
module test_cmdRspEngine;
  localparam int DEPTH = 320;
  localparam logic [1:0] FAM = 2'b01;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BURST_W = (CNT_W > 8) ? CNT_W : 8;

  logic clk = 1'b0, rstN = 1'b0, isActive = 1'b1;
  logic wrEn = 0, wrSel = 0, rdFifo = 0, byteView = 0;
  logic [7:0] wrData = 0, rdData, stsOut, rspData = 0;
  logic [BURST_W-1:0] burstCount;
  logic [2:0] engState;
  logic evReady, evValid, evData, execStart, cancelReq;
  logic [CNT_W-1:0] execLen;
  logic rspWrEn = 0, execDone = 0, execSelftest = 0;
  logic [ADDR_W-1:0] rspAddr = 0;

  cmdRspEngine #(.DEPTH(DEPTH), .FAMILY(FAM)) i_cmdRspEngine (.*);

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit done = 0;
  bit stExp = 0;
  logic [7:0] cRd;
  logic cEvR, cEvV, cEvD, cStart, cCancel;
  int cLen;
  logic [7:0] rsp [64];

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stsVal(bit rdy, bit vld, bit dav, bit ex);
    return {FAM, stExp, ex, dav, vld, rdy};
  endfunction

  function automatic logic [7:0] hdrByte(int len, int i);
    return 8'(len >> (8 * (5 - i)));
  endfunction

  // starts and ends just after a falling edge
  task automatic op(bit w, bit sel, logic [7:0] d, bit rd);
    wrEn = w; wrSel = sel; wrData = d; rdFifo = rd;
    #1;
    cRd = rdData; cEvR = evReady; cEvV = evValid; cEvD = evData;
    cStart = execStart; cCancel = cancelReq; cLen = int'(execLen);
    @(negedge clk);
    wrEn = 0; rdFifo = 0;
  endtask

  task automatic rspPut(int a, logic [7:0] d);
    rspWrEn = 1; rspAddr = ADDR_W'(a); rspData = d;
    @(negedge clk);
    rspWrEn = 0;
  endtask

  task automatic finishExec(bit st);
    execDone = 1; execSelftest = st;
    #1;
    cEvR = evReady; cEvV = evValid; cEvD = evData;
    @(negedge clk);
    execDone = 0; execSelftest = 0;
    stExp = stExp | st;
  endtask

  task automatic sendCmd(int len, int nBytes);
    for (int i = 0; i < nBytes; i++)
      op(1, 0, (i >= 2 && i <= 5) ? hdrByte(len, i) : 8'($urandom), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", engState, 0);
    chk("R1 sts", stsOut, stsVal(0, 0, 0, 0));
    chk("R1 burst", burstCount, DEPTH);
    byteView = 1; #1;
    chk("R11 byte-view cap", burstCount, 255);
    byteView = 0;
    // R5 write in IDLE dropped
    op(1, 0, 8'h12, 0);
    chk("R5 idle write state", engState, 0);
    chk("R5 idle write burst", burstCount, DEPTH);
    // R2 multi-bit and inactive writes ignored
    op(1, 1, 8'h03, 0);
    chk("R2 two bits", engState, 0);
    isActive = 0; op(1, 1, 8'h01, 0); isActive = 1;
    chk("R2 inactive", engState, 0);
    // R3
    op(1, 1, 8'h01, 0);
    chk("R3 evReady", cEvR, 1);
    chk("R3 to READY", engState, 1);
    chk("R3 ready flag", stsOut, stsVal(1, 0, 0, 0));
    op(1, 1, 8'h01, 0);
    chk("R3 repeat no event", cEvR, 0);
    chk("R3 repeat state", engState, 1);
    op(1, 1, 8'h04, 0);
    chk("R12 retry in READY", engState, 1);
    isActive = 0; op(1, 0, 8'h55, 0); isActive = 1;
    chk("R5 inactive fifo write", engState, 1);

    for (int it = 0; it < 20; it++) begin
      int len = 6 + int'($urandom % 35);
      int m = 6 + int'($urandom % 25);
      int k;
      bit st = 1'($urandom);
      if (engState == 3'd2) begin
        op(1, 1, 8'h01, 0);
        chk("R13 evReady", cEvR, 1);
        chk("R13 state", engState, 1);
        chk("R13 sts", stsOut, stsVal(1, 0, 0, 0));
      end
      for (int i = 0; i < len; i++) begin
        op(1, 0, (i >= 2 && i <= 5) ? hdrByte(len, i) : 8'($urandom), 0);
        chk("R5 recv state", engState, 4);
        chk("R6 expect", stsOut, stsVal(0, 1, 0, (i + 1 <= 5) || (len > i + 1)));
        chk("R11 free space", burstCount, DEPTH - (i + 1));
        if (i == 2) begin
          op(1, 1, 8'h02, 0);
          chk("R8 early go ignored", engState, 4);
        end
      end
      op(1, 0, 8'hAA, 0);
      chk("R6 write after complete", burstCount, DEPTH - len);
      op(1, 1, 8'h02, 0);
      chk("R8 start", cStart, 1);
      chk("R8 execLen", cLen, len);
      chk("R8 state", engState, 3);
      op(1, 0, 8'h77, 0);
      chk("R5 exec write dropped", burstCount, DEPTH - len);
      for (int i = 0; i < m; i++) begin
        rsp[i] = (i >= 2 && i <= 5) ? hdrByte(m, i) : 8'($urandom);
        rspPut(i, rsp[i]);
      end
      finishExec(st);
      chk("R9 evData", cEvD, 1);
      chk("R9 evValid", cEvV, 1);
      chk("R9 state", engState, 2);
      chk("R9 sts", stsOut, stsVal(0, 1, 1, 0));
      chk("R11 remaining", burstCount, m);
      k = int'($urandom % m);
      for (int i = 0; i < k; i++) begin
        op(0, 0, 0, 1);
        chk("R10 data", cRd, rsp[i]);
      end
      if (it == 0) begin
        isActive = 0; op(0, 0, 0, 1); isActive = 1;
        chk("R10 inactive read", cRd, 8'hFF);
        chk("R10 inactive no move", burstCount, m - k);
      end
      if (it % 2 == 1) begin
        op(1, 1, 8'h04, 0);
        chk("R12 retry burst", burstCount, m);
        chk("R12 retry sts", stsOut, stsVal(0, 1, 1, 0));
        k = 0;
      end
      for (int i = k; i < m; i++) begin
        op(0, 0, 0, 1);
        chk("R10 data", cRd, rsp[i]);
      end
      chk("R10 last evValid", cEvV, 1);
      chk("R10 last sts", stsOut, stsVal(0, 1, 0, 0));
      op(0, 0, 0, 1);
      chk("R10 no-data byte", cRd, 8'hFF);
      chk("R11 after drain", burstCount, DEPTH - m);
      chk("R14 family", stsOut[6:5], FAM);
    end

    // R4 abort in RECEPTION
    op(1, 1, 8'h01, 0);
    sendCmd(20, 3);
    op(1, 1, 8'h01, 0);
    chk("R4 recv abort event", cEvR, 1);
    chk("R4 recv abort state", engState, 1);
    chk("R4 recv abort burst", burstCount, DEPTH);
    chk("R4 recv abort sts", stsOut, stsVal(1, 0, 0, 0));
    // R4 abort in EXECUTION
    sendCmd(6, 6);
    op(1, 1, 8'h02, 0);
    op(1, 1, 8'h01, 0);
    chk("R4 cancelReq", cCancel, 1);
    chk("R4 still exec", engState, 3);
    finishExec(1);
    chk("R4 exec abort event", cEvR, 1);
    chk("R4 exec abort state", engState, 1);
    chk("R4 exec abort sts", stsOut, stsVal(1, 0, 0, 0));
    // R7 overflow
    sendCmd(1000, DEPTH);
    chk("R7 expect at full", stsOut, stsVal(0, 1, 0, 1));
    chk("R7 burst zero", burstCount, 0);
    op(1, 0, 8'h5A, 0);
    chk("R7 expect cleared", stsOut, stsVal(0, 1, 0, 0));
    op(1, 1, 8'h02, 0);
    chk("R8 go after overflow", cLen, DEPTH);
    for (int i = 0; i < 8; i++) rspPut(i, (i >= 2 && i <= 5) ? hdrByte(8, i) : 8'(i));
    finishExec(0);
    chk("R9 state after overflow", engState, 2);
    op(1, 1, 8'h01, 0);
    chk("R13 dav cleared", stsOut, stsVal(1, 0, 0, 0));
    chk("R13 state", engState, 1);
    chk("R14 selftest held", stsOut[4], 1);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule